// File: doc/BRIEF.md
# ADC Output Data Formatter

This block sits between a pipelined converter core and the output pins of a data converter. It takes one 14-bit offset-binary sample per sample clock and a raw out-of-range flag. It recodes each sample into offset binary, two's complement or Gray code. A test-pattern generator can replace the live data. Configuration inputs from the register file select the coding, the pattern, the output standard, the strobe polarity and the over-range settings.

The formatted word leaves the block in one of two ways. In single-rate mode it is a 14-bit word with a data-valid strobe. In double-rate mode it is spread over 7 lanes, and each lane carries two adjacent bits, one in each half of the clock period. A separate fast over-range flag warns that a sample is close to either end of the scale. It rises a fixed four clock edges after the sample, and its margin is programmable. The selections are captured together with the sample they apply to, so no output word mixes two settings.

Top module: `adc_out_formatter`

## Requirements
- R1: While rst_ni is low, data_o, lanes_o, otr_o and fast_otr_o are all zero.
- R2: With coding_i = 0 (offset binary) and tpat_i = 0, data_o shows the sample_i value captured two rising edges earlier, unchanged.
- R3: With coding_i = 1 (two's complement), data_o equals the captured sample with bit 13 inverted.
- R4: With coding_i = 2 (Gray), data_o equals b ^ (b >> 1), where b is the captured sample. coding_i = 3 behaves as offset binary.
- R5: Fixed patterns bypass the coding: tpat_i = 1 gives 0x2000, tpat_i = 2 gives 0x0000 and tpat_i = 3 gives 0x3FFF.
- R6: Sequenced patterns use a step count n. n is 0 for the first word after tpat_i changes and goes up by one per word after that. With tpat_i = 4, even n gives 0x1555 and odd n gives 0x2AAA. With tpat_i = 5, the word is n modulo 2^14. With tpat_i = 7, even n gives 0x0000 and odd n gives 0x3FFF.
- R7: tpat_i = 6 outputs the user word {user_hi_i[5:0], user_lo_i[7:0]}. user_hi_i supplies bits 13..8.
- R8: otr_o follows otr_i with the same two-edge latency as the data.
- R9: With fotr_en_i set at capture, fast_otr_o goes high after the fourth rising edge, counting the capturing edge, for any sample that meets one of these conditions: otr_i is set, the sample is below M, or the sample is at least 2^14 − M. Here M = 2^(fotr_thr_i + 5). With fotr_en_i clear, the flag for that sample is 0.
- R10: With ddr_en_i = 1, data_o is zero, and lane k carries bit 2k while clk_i is high and bit 2k+1 while clk_i is low. With ddr_en_i = 0, lanes_o is zero.
- R11: dav_o equals ~clk_i in single-rate mode and clk_i in double-rate mode. It is inverted when dav_inv_i = 1.
- R12: Coding, pattern, user word, output mode and strobe polarity are captured at the same edge as the sample. A change on any cycle therefore affects exactly the words captured from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 14 | Offset-binary sample from the core |
| otr_i | input | 1 | Raw out-of-range flag for sample_i |
| coding_i | input | 2 | 0 offset binary, 1 two's complement, 2 Gray, 3 offset binary |
| tpat_i | input | 3 | Test pattern select, 0 = live data |
| user_hi_i | input | 8 | User pattern upper byte (bits 5..0 used) |
| user_lo_i | input | 8 | User pattern lower byte |
| ddr_en_i | input | 1 | 1 selects double-rate lane output |
| dav_inv_i | input | 1 | Inverts the data-valid strobe |
| fotr_en_i | input | 1 | Enables the fast over-range flag |
| fotr_thr_i | input | 3 | Fast over-range margin exponent |
| data_o | output | 14 | Single-rate output word |
| lanes_o | output | 7 | Double-rate lanes, two bits per lane |
| dav_o | output | 1 | Data-valid strobe |
| otr_o | output | 1 | Out-of-range flag aligned with data |
| fast_otr_o | output | 1 | Fast over-range flag |

## Verification
The assertions assume that every configuration input is synchronous to clk_i and stable around the rising edge, just like sample_i. The bench meets this by changing every input only after the falling edge. It checks lane and strobe values in the middle of each clock phase, because those outputs follow clk_i combinationally. The bench steps through each coding and each pattern mode. It places samples one code either side of each over-range margin, and it finishes with a run in which every setting changes at random on every cycle.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;
  typedef enum logic [1:0] {
    CODE_OFFSET = 2'd0,
    CODE_TWOS   = 2'd1,
    CODE_GRAY   = 2'd2,
    CODE_RSVD   = 2'd3
  } coding_e;

  typedef enum logic [2:0] {
    TP_OFF    = 3'd0,
    TP_MID    = 3'd1,
    TP_ZERO   = 3'd2,
    TP_FULL   = 3'd3,
    TP_CHECK  = 3'd4,
    TP_RAMP   = 3'd5,
    TP_USER   = 3'd6,
    TP_TOGGLE = 3'd7
  } tpat_e;

  typedef struct packed {
    coding_e coding;
    tpat_e   tpat;
    logic    ddr_en;
    logic    dav_inv;
  } cfg_t;
endpackage

// File: rtl/adcfmt_pattern.sv
module adcfmt_pattern
  import adcfmt_pkg::*;
#(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  tpat_e        tpat_i,
  input  logic [W-1:0] user_i,
  output logic [W-1:0] pat_o,
  output logic         act_o
);
  localparam logic [W-1:0] ALT_LO = {(W/2){2'b01}};
  localparam logic [W-1:0] MID    = {1'b1, {(W-1){1'b0}}};

  tpat_e        prev_q;
  logic [W-1:0] seq_q, seq_n;

  // step count restarts on any mode change
  assign seq_n = (tpat_i != prev_q) ? '0 : seq_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= TP_OFF;
      seq_q  <= '0;
    end else begin
      prev_q <= tpat_i;
      seq_q  <= seq_n;
    end
  end

  always_comb begin
    pat_o = '0;
    unique case (tpat_i)
      TP_MID:    pat_o = MID;
      TP_ZERO:   pat_o = '0;
      TP_FULL:   pat_o = '1;
      TP_CHECK:  pat_o = seq_n[0] ? ~ALT_LO : ALT_LO;
      TP_RAMP:   pat_o = seq_n;
      TP_USER:   pat_o = user_i;
      TP_TOGGLE: pat_o = seq_n[0] ? '1 : '0;
      default:   pat_o = '0;
    endcase
  end

  assign act_o = (tpat_i != TP_OFF);
endmodule

// File: rtl/adcfmt_encode.sv
module adcfmt_encode
  import adcfmt_pkg::*;
#(
  parameter int W = 14
) (
  input  coding_e      coding_i,
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] code_o
);
  always_comb begin
    unique case (coding_i)
      CODE_TWOS: code_o = {~bin_i[W-1], bin_i[W-2:0]};
      CODE_GRAY: code_o = bin_i ^ (bin_i >> 1);
      default:   code_o = bin_i;
    endcase
  end
endmodule

// File: rtl/adcfmt_fast_ovr.sv
module adcfmt_fast_ovr #(
  parameter int W     = 14,
  parameter int LAT   = 4,
  parameter int SHIFT = 5,
  parameter int THR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     sample_i,
  input  logic             otr_i,
  input  logic             en_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             flag_o
);
  localparam logic [W:0] FULL = {1'b1, {W{1'b0}}};

  logic [W:0]     margin;
  logic           trip;
  logic [LAT-1:0] sh_q;

  assign margin = (W+1)'(1) << (thr_i + SHIFT);
  assign trip   = otr_i
                | ({1'b0, sample_i} < margin)
                | (({1'b0, sample_i} + margin) >= FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[LAT-2:0], en_i & trip};
  end

  assign flag_o = sh_q[LAT-1];
endmodule

// File: rtl/adcfmt_lane_pack.sv
module adcfmt_lane_pack #(
  parameter int W     = 14,
  parameter int LANES = W / 2
) (
  input  logic             clk_i,
  input  logic             ddr_i,
  input  logic [W-1:0]     word_i,
  output logic [LANES-1:0] lanes_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    // even bit in high phase, odd bit in low phase
    assign lanes_o[k] = ddr_i & (clk_i ? word_i[2*k] : word_i[2*k+1]);
  end
endmodule

// File: rtl/adc_out_formatter.sv
module adc_out_formatter
  import adcfmt_pkg::*;
#(
  parameter int W     = 14,
  parameter int LANES = W / 2,
  parameter int UHI_W = W - 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     sample_i,
  input  logic             otr_i,
  input  logic [1:0]       coding_i,
  input  logic [2:0]       tpat_i,
  input  logic [7:0]       user_hi_i,
  input  logic [7:0]       user_lo_i,
  input  logic             ddr_en_i,
  input  logic             dav_inv_i,
  input  logic             fotr_en_i,
  input  logic [2:0]       fotr_thr_i,
  output logic [W-1:0]     data_o,
  output logic [LANES-1:0] lanes_o,
  output logic             dav_o,
  output logic             otr_o,
  output logic             fast_otr_o
);
  // stage 1: sample with its configuration
  cfg_t         cfg_q;
  logic [W-1:0] smp_q, user_q;
  logic         otr1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      smp_q  <= '0;
      user_q <= '0;
      otr1_q <= 1'b0;
    end else begin
      cfg_q  <= '{coding: coding_e'(coding_i), tpat: tpat_e'(tpat_i),
                  ddr_en: ddr_en_i, dav_inv: dav_inv_i};
      smp_q  <= sample_i;
      user_q <= {user_hi_i[UHI_W-1:0], user_lo_i};
      otr1_q <= otr_i;
    end
  end

  logic [W-1:0] code_w, pat_w;
  logic         pat_act;

  adcfmt_encode #(.W(W)) u_enc (
    .coding_i (cfg_q.coding),
    .bin_i    (smp_q),
    .code_o   (code_w)
  );

  adcfmt_pattern #(.W(W)) u_pat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tpat_i (cfg_q.tpat),
    .user_i (user_q),
    .pat_o  (pat_w),
    .act_o  (pat_act)
  );

  // stage 2: output word
  logic [W-1:0] word_q;
  logic         ddr_q, inv_q, otr2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      ddr_q  <= 1'b0;
      inv_q  <= 1'b0;
      otr2_q <= 1'b0;
    end else begin
      word_q <= pat_act ? pat_w : code_w;
      ddr_q  <= cfg_q.ddr_en;
      inv_q  <= cfg_q.dav_inv;
      otr2_q <= otr1_q;
    end
  end

  adcfmt_fast_ovr #(.W(W), .LAT(4), .SHIFT(5), .THR_W(3)) u_fovr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample_i),
    .otr_i    (otr_i),
    .en_i     (fotr_en_i),
    .thr_i    (fotr_thr_i),
    .flag_o   (fast_otr_o)
  );

  adcfmt_lane_pack #(.W(W), .LANES(LANES)) u_lane (
    .clk_i   (clk_i),
    .ddr_i   (ddr_q),
    .word_i  (word_q),
    .lanes_o (lanes_o)
  );

  assign data_o = ddr_q ? '0 : word_q;
  assign otr_o  = otr2_q;
  assign dav_o  = (ddr_q ? clk_i : ~clk_i) ^ inv_q;
endmodule

// File: rtl/adcfmt_chk.sv
module adcfmt_chk #(
  parameter int W = 14
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] sample_i,
  input logic         otr_i,
  input logic [1:0]   coding_i,
  input logic [2:0]   tpat_i,
  input logic [7:0]   user_hi_i,
  input logic [7:0]   user_lo_i,
  input logic         ddr_en_i,
  input logic         fotr_en_i,
  input logic [W-1:0] data_o,
  input logic         otr_o,
  input logic         fast_otr_o
);
  logic [2:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 3'd7) cyc_q <= cyc_q + 1'b1;
  end

  // R2
  ob_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 3'd2 && $past(coding_i == 2'd0 && tpat_i == 3'd0 && !ddr_en_i, 2))
      |-> data_o == $past(sample_i, 2));

  // R3
  twos_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 3'd2 && $past(coding_i == 2'd1 && tpat_i == 3'd0 && !ddr_en_i, 2))
      |-> (data_o[W-1] != $past(sample_i[W-1], 2)) && (data_o[W-2:0] == $past(sample_i[W-2:0], 2)));

  // R7
  user_pat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 3'd2 && $past(tpat_i == 3'd6 && !ddr_en_i, 2))
      |-> data_o == {$past(user_hi_i[W-9:0], 2), $past(user_lo_i, 2)});

  // R8
  otr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 3'd2) |-> otr_o == $past(otr_i, 2));

  // R9
  fast_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 3'd4 && $past(fotr_en_i && otr_i, 4)) |-> fast_otr_o);

  // R9
  fast_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 3'd4 && $past(!fotr_en_i, 4)) |-> !fast_otr_o);

  // R10
  ddr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 3'd2 && $past(ddr_en_i, 2)) |-> data_o == '0);
endmodule

bind adc_out_formatter adcfmt_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sample_i   (sample_i),
  .otr_i      (otr_i),
  .coding_i   (coding_i),
  .tpat_i     (tpat_i),
  .user_hi_i  (user_hi_i),
  .user_lo_i  (user_lo_i),
  .ddr_en_i   (ddr_en_i),
  .fotr_en_i  (fotr_en_i),
  .data_o     (data_o),
  .otr_o      (otr_o),
  .fast_otr_o (fast_otr_o)
);

// File: tb/adc_out_formatter_tb_top.sv
`timescale 1ns/1ps
module adc_out_formatter_tb_top;
  localparam int W = 14;
  localparam int L = 7;
  localparam int FS = 1 << W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic [W-1:0] sample = '0;
  logic         otr = 1'b0;
  logic [1:0]   coding = '0;
  logic [2:0]   tpat = '0;
  logic [7:0]   uhi = '0, ulo = '0;
  logic         ddr = 1'b0, inv = 1'b0, fen = 1'b0;
  logic [2:0]   thr = '0;

  logic [W-1:0] data_o;
  logic [L-1:0] lanes_o;
  logic         dav_o, otr_o, fast_o;

  adc_out_formatter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .otr_i(otr),
    .coding_i(coding), .tpat_i(tpat), .user_hi_i(uhi), .user_lo_i(ulo),
    .ddr_en_i(ddr), .dav_inv_i(inv), .fotr_en_i(fen), .fotr_thr_i(thr),
    .data_o(data_o), .lanes_o(lanes_o), .dav_o(dav_o), .otr_o(otr_o),
    .fast_otr_o(fast_o));

  int n_cmp = 0, n_bad = 0;
  string tag_ovr = "";
  bit done = 0;

  // reference model state
  int s1_smp, s1_cod, s1_tp, s1_user;
  bit s1_otr, s1_ddr, s1_inv;
  int o_word, prev_tp, seq;
  bit o_ddr, o_inv, o_otr;
  bit fq[$];
  string o_tag;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int trip(int s, bit o, int t);
    int m = 1 << (t + 5);
    return (o || s < m || s >= FS - m) ? 1 : 0;
  endfunction

  task automatic model_edge();
    int w;
    if (!rst_n) begin
      s1_smp = 0; s1_cod = 0; s1_tp = 0; s1_user = 0;
      s1_otr = 0; s1_ddr = 0; s1_inv = 0;
      o_word = 0; o_ddr = 0; o_inv = 0; o_otr = 0;
      prev_tp = 0; seq = 0;
      fq = '{0, 0, 0, 0};
      return;
    end
    seq = (s1_tp != prev_tp) ? 0 : (seq + 1) % FS;
    prev_tp = s1_tp;
    case (s1_tp)
      1: begin w = FS / 2; o_tag = "R5"; end
      2: begin w = 0; o_tag = "R5"; end
      3: begin w = FS - 1; o_tag = "R5"; end
      4: begin w = (seq % 2) ? 'h2AAA : 'h1555; o_tag = "R6"; end
      5: begin w = seq; o_tag = "R6"; end
      6: begin w = s1_user; o_tag = "R7"; end
      7: begin w = (seq % 2) ? FS - 1 : 0; o_tag = "R6"; end
      default: begin
        if (s1_cod == 1)      begin w = s1_smp ^ (FS / 2); o_tag = "R3"; end
        else if (s1_cod == 2) begin w = s1_smp ^ (s1_smp >> 1); o_tag = "R4"; end
        else                  begin w = s1_smp; o_tag = (s1_cod == 3) ? "R4" : "R2"; end
      end
    endcase
    if (tag_ovr != "") o_tag = tag_ovr;
    o_word = w; o_ddr = s1_ddr; o_inv = s1_inv; o_otr = s1_otr;
    void'(fq.pop_back());
    fq.push_front(bit'(fen && trip(int'(sample), otr, int'(thr))));
    s1_smp = sample; s1_cod = coding; s1_tp = tpat;
    s1_user = {uhi[5:0], ulo}; s1_otr = otr; s1_ddr = ddr; s1_inv = inv;
  endtask

  task automatic step();
    int ev, od;
    @(posedge clk);
    model_edge();
    #1;
    if (!rst_n) begin
      chk("R1 data", data_o, 0); chk("R1 lanes", lanes_o, 0);
      chk("R1 otr", otr_o, 0);   chk("R1 fast", fast_o, 0);
    end else begin
      ev = 0; od = 0;
      for (int k = 0; k < L; k++) begin
        ev[k] = o_word[2*k];
        od[k] = o_word[2*k+1];
      end
      chk(o_ddr ? "R10 data" : o_tag, data_o, o_ddr ? 0 : o_word);
      chk("R10 lanes hi", lanes_o, o_ddr ? ev : 0);
      chk("R11 dav hi", dav_o, (o_ddr ? 1 : 0) ^ o_inv);
      chk("R8 otr", otr_o, o_otr);
      chk("R9 fast", fast_o, fq[3]);
    end
    @(negedge clk);
    #1;
    if (rst_n) begin
      chk("R10 lanes lo", lanes_o, o_ddr ? od : 0);
      chk("R11 dav lo", dav_o, (o_ddr ? 0 : 1) ^ o_inv);
    end
  endtask

  task automatic rnd_sample();
    sample = W'($urandom);
    otr = ($urandom % 8) == 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();                 // R1
    rst_n = 1'b1;
    // codings R2 R3 R4, with scale ends
    for (int c = 0; c < 4; c++) begin
      coding = 2'(c);
      sample = '0; step();
      sample = '1; step();
      sample = W'(FS / 2); step();
      repeat (30) begin rnd_sample(); step(); end
    end
    // test patterns R5 R6 R7
    for (int p = 1; p < 8; p++) begin
      tpat = 3'(p);
      uhi = 8'($urandom); ulo = 8'($urandom);
      repeat (20) begin rnd_sample(); coding = 2'($urandom); step(); end
    end
    tpat = 3'd5; repeat (5) step();
    tpat = 3'd4; repeat (5) step();  // R6 restart on change
    tpat = 3'd0; coding = 2'd0;
    // fast over-range margins R9
    fen = 1'b1;
    for (int t = 0; t < 8; t++) begin
      int m = 1 << (t + 5);
      thr = 3'(t); otr = 1'b0;
      sample = W'(m - 1);      step();
      sample = W'(m);          step();
      sample = W'(FS - m);     step();
      sample = W'(FS - m - 1); step();
      otr = 1'b1; sample = W'(FS / 2); step();
      otr = 1'b0; repeat (4) step();
    end
    fen = 1'b0; otr = 1'b1; sample = '0; repeat (6) step();
    otr = 1'b0;
    // DDR lanes and strobe R10 R11
    ddr = 1'b1;
    for (int i = 0; i < 2; i++) begin
      inv = 1'(i);
      repeat (25) begin rnd_sample(); step(); end
    end
    ddr = 1'b0; inv = 1'b1; repeat (10) begin rnd_sample(); step(); end
    // per-cycle config changes R12
    tag_ovr = "R12";
    repeat (400) begin
      rnd_sample();
      coding = 2'($urandom); tpat = 3'($urandom % 10 > 6 ? $urandom : 0);
      uhi = 8'($urandom); ulo = 8'($urandom);
      ddr = 1'($urandom); inv = 1'($urandom);
      fen = 1'($urandom); thr = 3'($urandom);
      step();
    end
    repeat (6) step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule